// File: doc/BRIEF.md
# Precise Trap and Privilege Controller

This block is the trap control unit of a small in-order pipeline. Each tracked pipeline stage can report a synchronous fault for the instruction it holds, or flag that instruction as privileged. The block also takes one external interrupt line and has its own programmable tick source. When it accepts a trap, it records the restart PC and a cause code, and latches the faulting data address for memory faults. It saves the user stack pointer and the previous privilege level. In one step it enters kernel mode, loads the kernel stack pointer, steers fetch to a fixed handler address and flushes the faulting instruction together with everything younger.

A return-from-exception input, honoured only in kernel mode, reverses the swap in one step. It restores the saved mode and stack pointer, redirects fetch to the recorded PC and re-enables trap acceptance. While a trap is being serviced, further traps are masked so that the recorded PC and cause survive. Interrupts and ticks that arrive while traps are masked wait in pending flags. All outputs are registered, so every response appears one clock after the cycle in which its request is presented.

Top module: `trap_unit`

## Requirements
- R1: After reset the block is in kernel mode (`kernel_mode`=1), trap acceptance is off (`exc_en`=0), no redirect, flush or stack write is issued, `epc` equals the boot PC (0 by default) and the tick period equals its reset value.
- R2: With `exc_en`=1, a stage fault presented in cycle T gives, in cycle T+1, `redirect_vld`=1 with `redirect_pc` equal to the handler vector (0x80000180 by default), `epc` equal to that stage's PC, and `cause` equal to the reported code. The codes are: 0 external interrupt, 1 tick, 2 syscall, 3 overflow, 4 divide by zero, 5 bad address, 6 page fault, 7 privilege violation. `flush_stages` has bit i set for the faulting stage i and every younger stage (lower index).
- R3: When several stages fault in one cycle, the oldest one wins. The oldest stage is the one with the highest index.
- R4: On trap entry the block saves the incoming `cur_sp` into `saved_sp` and the old mode into `saved_mode`. It pulses `sp_wr` with `sp_wdata`=`kernel_sp` and sets `kernel_mode`.
- R5: Trap entry clears `exc_en`. While it is 0, stage faults are ignored: there is no redirect, and `epc`, `cause` and `badvaddr` keep their values.
- R6: A stage flagged privileged in user mode, without a fault of its own, traps with cause 7.
- R7: `badvaddr` is loaded from the winning stage's address only for causes 5 and 6. Other causes leave it unchanged.
- R8: In kernel mode, `eret_in` gives a redirect to `epc` the next cycle, with all flush bits set. It restores the mode from `saved_mode`, writes `saved_sp` to the stack pointer and sets `exc_en`. In user mode `eret_in` is ignored.
- R9: Interrupts and ticks are taken only when trap acceptance is on and no stage faults that cycle. The external interrupt beats the tick. `epc` gets the oldest stage's PC and all flush bits are set. An interrupt seen while masked stays pending until it is taken.
- R10: Only in kernel mode does `tick_wr_en` load the tick period. The load restarts the down-counter and drops any pending tick. A period of N > 0 raises a pending tick N cycles after the load. A period of 0 stops the timer. In user mode the load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_exc_vld | input | NSTAGE | Per-stage fault request, index NSTAGE-1 oldest |
| stage_exc_cause | input | NSTAGE*3 | Per-stage fault code |
| stage_priv_op | input | NSTAGE | Per-stage privileged-instruction flag |
| stage_pc | input | NSTAGE*XLEN | Per-stage instruction PC |
| stage_addr | input | NSTAGE*XLEN | Per-stage data address |
| irq_in | input | 1 | External interrupt request |
| eret_in | input | 1 | Return-from-exception request |
| cur_sp | input | XLEN | Current stack pointer value |
| kernel_sp | input | XLEN | Kernel stack pointer value |
| tick_wr_en | input | 1 | Tick period write strobe |
| tick_wr_data | input | TICK_W | Tick period value |
| redirect_vld | output | 1 | Fetch redirect pulse |
| redirect_pc | output | XLEN | Redirect target |
| flush_stages | output | NSTAGE | Stages to squash |
| sp_wr | output | 1 | Stack pointer write pulse |
| sp_wdata | output | XLEN | New stack pointer value |
| kernel_mode | output | 1 | Current privilege level, 1 is kernel |
| exc_en | output | 1 | Trap acceptance enabled |
| epc | output | XLEN | Recorded restart PC |
| cause | output | 3 | Recorded cause code |
| badvaddr | output | XLEN | Recorded faulting address |
| saved_mode | output | 1 | Privilege level before the trap |
| saved_sp | output | XLEN | Stack pointer before the trap |
| tick_period | output | TICK_W | Current tick period |

## Verification
The bench builds the block with three stages, a 32-bit word, an 8-bit tick period and a tick reset value of 0. With that reset value the timer stays silent until kernel code loads a period, so the tick can be placed deliberately. The three stages make it possible to drive simultaneous faults at the youngest, middle and oldest positions and to tell the flush masks apart. Short periods of 2 and 4 let the bench stack an interrupt against a pending tick and time a tick trap to the exact cycle within a few clocks.

// File: rtl/trap_pkg.sv
`timescale 1ns/1ps
package trap_pkg;
  localparam int CAUSE_W = 3;
  typedef logic [CAUSE_W-1:0] cause_t;
  localparam cause_t CA_IRQ     = 3'd0;
  localparam cause_t CA_TICK    = 3'd1;
  localparam cause_t CA_SYSCALL = 3'd2;
  localparam cause_t CA_OVF     = 3'd3;
  localparam cause_t CA_DIVZ    = 3'd4;
  localparam cause_t CA_BADADDR = 3'd5;
  localparam cause_t CA_PGFAULT = 3'd6;
  localparam cause_t CA_PRIV    = 3'd7;
endpackage

// File: rtl/trap_prio.sv
`timescale 1ns/1ps
module trap_prio import trap_pkg::*; #(
  parameter int NSTAGE = 3,
  parameter int XLEN   = 32
) (
  input  logic                      user_mode,
  input  logic [NSTAGE-1:0]         exc_vld,
  input  logic [NSTAGE-1:0]         priv_op,
  input  logic [NSTAGE*CAUSE_W-1:0] exc_cause,
  input  logic [NSTAGE*XLEN-1:0]    pc_flat,
  input  logic [NSTAGE*XLEN-1:0]    addr_flat,
  output logic                      hit,
  output cause_t                    hit_cause,
  output logic [XLEN-1:0]           hit_pc,
  output logic [XLEN-1:0]           hit_addr,
  output logic [NSTAGE-1:0]         hit_flush
);
  logic [NSTAGE-1:0] req;
  cause_t            scause [NSTAGE];

  // each stage: its own fault, or a privileged op attempted from user mode
  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    assign req[g]    = exc_vld[g] | (priv_op[g] & user_mode);
    assign scause[g] = exc_vld[g] ? exc_cause[g*CAUSE_W +: CAUSE_W] : CA_PRIV;
  end

  // ascending scan: the last (oldest) requester overrides younger ones
  always_comb begin
    hit       = 1'b0;
    hit_cause = CA_IRQ;
    hit_pc    = '0;
    hit_addr  = '0;
    hit_flush = '0;
    for (int i = 0; i < NSTAGE; i++) begin
      if (req[i]) begin
        hit       = 1'b1;
        hit_cause = scause[i];
        hit_pc    = pc_flat[i*XLEN +: XLEN];
        hit_addr  = addr_flat[i*XLEN +: XLEN];
        hit_flush = {NSTAGE{1'b1}} >> (NSTAGE-1-i);
      end
    end
  end
endmodule

// File: rtl/trap_tick.sv
`timescale 1ns/1ps
module trap_tick #(
  parameter int              TICK_W     = 16,
  parameter logic [TICK_W-1:0] TICK_RESET = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [TICK_W-1:0] wr_data,
  input  logic              take,
  output logic [TICK_W-1:0] period,
  output logic              pend
);
  logic [TICK_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      period <= TICK_RESET;
      cnt    <= TICK_RESET;
      pend   <= 1'b0;
    end else if (wr_en) begin
      period <= wr_data;
      cnt    <= wr_data;
      pend   <= 1'b0;
    end else begin
      if (take) pend <= 1'b0;
      if (period != '0) begin
        if (cnt <= TICK_W'(1)) begin
          cnt  <= period;
          pend <= 1'b1;
        end else begin
          cnt <= cnt - TICK_W'(1);
        end
      end
    end
  end

  // R10: the down-counter never exceeds the programmed period
  assert_count_bounded_R10: assert property (@(posedge clk) disable iff (rst)
    (period != '0) |-> (cnt <= period));
  // R10: a load restarts the count and drops a pending tick
  assert_load_restarts_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (!pend && cnt == $past(wr_data) && period == $past(wr_data)));
endmodule

// File: rtl/trap_unit.sv
`timescale 1ns/1ps
module trap_unit import trap_pkg::*; #(
  parameter int                NSTAGE     = 3,
  parameter int                XLEN       = 32,
  parameter int                TICK_W     = 16,
  parameter logic [TICK_W-1:0] TICK_RESET = '0,
  parameter logic [XLEN-1:0]   VECTOR     = XLEN'(32'h8000_0180),
  parameter logic [XLEN-1:0]   BOOT_PC    = '0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NSTAGE-1:0]         stage_exc_vld,
  input  logic [NSTAGE*CAUSE_W-1:0] stage_exc_cause,
  input  logic [NSTAGE-1:0]         stage_priv_op,
  input  logic [NSTAGE*XLEN-1:0]    stage_pc,
  input  logic [NSTAGE*XLEN-1:0]    stage_addr,
  input  logic                      irq_in,
  input  logic                      eret_in,
  input  logic [XLEN-1:0]           cur_sp,
  input  logic [XLEN-1:0]           kernel_sp,
  input  logic                      tick_wr_en,
  input  logic [TICK_W-1:0]         tick_wr_data,
  output logic                      redirect_vld,
  output logic [XLEN-1:0]           redirect_pc,
  output logic [NSTAGE-1:0]         flush_stages,
  output logic                      sp_wr,
  output logic [XLEN-1:0]           sp_wdata,
  output logic                      kernel_mode,
  output logic                      exc_en,
  output logic [XLEN-1:0]           epc,
  output logic [CAUSE_W-1:0]        cause,
  output logic [XLEN-1:0]           badvaddr,
  output logic                      saved_mode,
  output logic [XLEN-1:0]           saved_sp,
  output logic [TICK_W-1:0]         tick_period
);
  localparam int OLDEST = NSTAGE - 1;
  localparam logic [NSTAGE-1:0] FLUSH_ALL = {NSTAGE{1'b1}};

  logic              sync_hit;
  cause_t            sync_cause;
  logic [XLEN-1:0]   sync_pc, sync_addr;
  logic [NSTAGE-1:0] sync_flush;
  logic              irq_pend, tick_pend;
  logic              take_sync, take_async, take, do_eret, take_tick, tick_load;
  cause_t            async_cause;

  trap_prio #(.NSTAGE(NSTAGE), .XLEN(XLEN)) i_prio (
    .user_mode (~kernel_mode),
    .exc_vld   (stage_exc_vld),
    .priv_op   (stage_priv_op),
    .exc_cause (stage_exc_cause),
    .pc_flat   (stage_pc),
    .addr_flat (stage_addr),
    .hit       (sync_hit),
    .hit_cause (sync_cause),
    .hit_pc    (sync_pc),
    .hit_addr  (sync_addr),
    .hit_flush (sync_flush)
  );

  // trap selection: synchronous first, then interrupt, then tick
  assign take_sync   = exc_en & sync_hit;
  assign take_async  = exc_en & ~sync_hit & (irq_pend | tick_pend);
  assign take        = take_sync | take_async;
  assign do_eret     = eret_in & kernel_mode & ~take;
  assign async_cause = irq_pend ? CA_IRQ : CA_TICK;
  assign take_tick   = take_async & ~irq_pend;
  assign tick_load   = tick_wr_en & kernel_mode;

  trap_tick #(.TICK_W(TICK_W), .TICK_RESET(TICK_RESET)) i_tick (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tick_load),
    .wr_data (tick_wr_data),
    .take    (take_tick),
    .period  (tick_period),
    .pend    (tick_pend)
  );

  // external interrupt pending flag: a new request wins over a same-cycle take
  always_ff @(posedge clk) begin
    if (rst)                         irq_pend <= 1'b0;
    else if (irq_in)                 irq_pend <= 1'b1;
    else if (take_async && irq_pend) irq_pend <= 1'b0;
  end

  // status registers, stack swap and redirect
  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_vld <= 1'b0;
      redirect_pc  <= '0;
      flush_stages <= '0;
      sp_wr        <= 1'b0;
      sp_wdata     <= '0;
      kernel_mode  <= 1'b1;
      exc_en       <= 1'b0;
      epc          <= BOOT_PC;
      cause        <= CA_IRQ;
      badvaddr     <= '0;
      saved_mode   <= 1'b0;
      saved_sp     <= '0;
    end else begin
      redirect_vld <= 1'b0;
      flush_stages <= '0;
      sp_wr        <= 1'b0;
      if (take) begin
        redirect_vld <= 1'b1;
        redirect_pc  <= VECTOR;
        flush_stages <= take_sync ? sync_flush : FLUSH_ALL;
        epc          <= take_sync ? sync_pc : stage_pc[OLDEST*XLEN +: XLEN];
        cause        <= take_sync ? sync_cause : async_cause;
        if (take_sync && (sync_cause == CA_BADADDR || sync_cause == CA_PGFAULT))
          badvaddr <= sync_addr;
        saved_mode   <= kernel_mode;
        saved_sp     <= cur_sp;
        sp_wr        <= 1'b1;
        sp_wdata     <= kernel_sp;
        kernel_mode  <= 1'b1;
        exc_en       <= 1'b0;
      end else if (do_eret) begin
        redirect_vld <= 1'b1;
        redirect_pc  <= epc;
        flush_stages <= FLUSH_ALL;
        sp_wr        <= 1'b1;
        sp_wdata     <= saved_sp;
        kernel_mode  <= saved_mode;
        exc_en       <= 1'b1;
      end
    end
  end

  // R2: a redirect that leaves traps masked goes to the handler in kernel mode
  assert_vector_R2: assert property (@(posedge clk) disable iff (rst)
    (redirect_vld && !exc_en) |-> (redirect_pc == VECTOR && kernel_mode));
  // R4: the level before entry is what gets saved
  assert_saved_mode_R4: assert property (@(posedge clk) disable iff (rst)
    take |=> (saved_mode == $past(kernel_mode) && sp_wr && kernel_mode));
  // R5: while masked and not returning, recorded state and fetch stay put
  assert_masked_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!exc_en && !eret_in) |=> ($stable(epc) && $stable(cause) && $stable(badvaddr) && !redirect_vld));
  // R8: a return attempted from user mode changes nothing
  assert_user_eret_R8: assert property (@(posedge clk) disable iff (rst)
    (eret_in && !kernel_mode && !take) |=> (!redirect_vld && !kernel_mode));
  // R9: a stage fault always beats a pending interrupt or tick
  assert_sync_first_R9: assert property (@(posedge clk) disable iff (rst)
    (exc_en && sync_hit) |=> (cause == $past(sync_cause) && epc == $past(sync_pc)));
endmodule

// File: tb/test_trap_unit.sv
`timescale 1ns/1ps
module test_trap_unit;
  localparam int NS = 3;
  localparam int XL = 32;
  localparam int TW = 8;
  localparam logic [31:0] VEC = 32'h8000_0180;

  logic clk = 1'b0;
  logic rst;
  logic [NS-1:0]    ev, pv;
  logic [NS*3-1:0]  ec;
  logic [NS*XL-1:0] spc, sad;
  logic irq, eret, twe;
  logic [TW-1:0] twd;
  logic [XL-1:0] csp, ksp;
  logic redirect_vld, sp_wr, kernel_mode, exc_en, saved_mode;
  logic [XL-1:0] redirect_pc, sp_wdata, epc, badvaddr, saved_sp;
  logic [NS-1:0] flush_stages;
  logic [2:0] cause;
  logic [TW-1:0] tick_period;

  always #2.5 clk = ~clk;

  trap_unit #(.NSTAGE(NS), .XLEN(XL), .TICK_W(TW), .TICK_RESET(8'd0)) i_trap_unit (
    .clk(clk), .rst(rst), .stage_exc_vld(ev), .stage_exc_cause(ec), .stage_priv_op(pv),
    .stage_pc(spc), .stage_addr(sad), .irq_in(irq), .eret_in(eret), .cur_sp(csp),
    .kernel_sp(ksp), .tick_wr_en(twe), .tick_wr_data(twd), .redirect_vld(redirect_vld),
    .redirect_pc(redirect_pc), .flush_stages(flush_stages), .sp_wr(sp_wr), .sp_wdata(sp_wdata),
    .kernel_mode(kernel_mode), .exc_en(exc_en), .epc(epc), .cause(cause), .badvaddr(badvaddr),
    .saved_mode(saved_mode), .saved_sp(saved_sp), .tick_period(tick_period));

  typedef struct {
    int          cyc;
    logic [31:0] pc;
    logic [2:0]  fl;
    logic        md;
    logic        trap;
    logic [31:0] ep;
    logic [2:0]  ca;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push_at(int at, logic [31:0] pc, logic [2:0] fl, logic md,
                         logic trap, logic [31:0] ep, logic [2:0] ca, string tag);
    exp_t e;
    e.cyc = at; e.pc = pc; e.fl = fl; e.md = md; e.trap = trap; e.ep = ep; e.ca = ca; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic push(logic [31:0] pc, logic [2:0] fl, logic md,
                      logic trap, logic [31:0] ep, logic [2:0] ca, string tag);
    push_at(cyc + 1, pc, fl, md, trap, ep, ca, tag);
  endtask

  task automatic clear_in();
    ev = '0; pv = '0; irq = 1'b0; eret = 1'b0; twe = 1'b0;
  endtask

  task automatic set_stage(int s, logic [2:0] c, logic [31:0] pc, logic [31:0] a);
    ev[s] = 1'b1;
    ec[s*3 +: 3] = c;
    spc[s*XL +: XL] = pc;
    sad[s*XL +: XL] = a;
  endtask

  task automatic step();
    @(posedge clk); #1;
    clear_in();
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  // monitor: pops expected redirects and compares them as they appear
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (redirect_vld) begin
        if (q.size() == 0) begin
          chk("R2 unexpected redirect", redirect_pc, 32'hffff_ffff);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk({e.tag, " cycle"}, cyc, e.cyc);
          chk({e.tag, " redirect_pc"}, redirect_pc, e.pc);
          chk({e.tag, " flush"}, {29'd0, flush_stages}, {29'd0, e.fl});
          chk({e.tag, " mode"}, {31'd0, kernel_mode}, {31'd0, e.md});
          if (e.trap) begin
            chk({e.tag, " epc"}, epc, e.ep);
            chk({e.tag, " cause"}, {29'd0, cause}, {29'd0, e.ca});
          end
        end
      end else if (q.size() > 0 && q[0].cyc <= cyc) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " missing redirect"}, 32'd0, 32'd1);
      end
    end
  end

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; clear_in(); ec = '0; spc = '0; sad = '0; twd = '0;
    csp = '0; ksp = 32'h9000_0000;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    settle();
    // R1 reset state
    chk("R1 kernel_mode", {31'd0, kernel_mode}, 32'd1);
    chk("R1 exc_en", {31'd0, exc_en}, 32'd0);
    chk("R1 redirect", {31'd0, redirect_vld}, 32'd0);
    chk("R1 flush", {29'd0, flush_stages}, 32'd0);
    chk("R1 epc", epc, 32'd0);
    chk("R1 tick_period", {24'd0, tick_period}, 32'd0);

    // R8: first return leaves boot into user mode at the boot PC
    eret = 1'b1; push(32'd0, 3'b111, 1'b0, 1'b0, 0, 0, "R8 boot"); step(); settle();
    chk("R8 exc_en", {31'd0, exc_en}, 32'd1);
    chk("R8 sp_wr", {31'd0, sp_wr}, 32'd1);
    chk("R8 sp_wdata", sp_wdata, 32'd0);

    // R2/R4: overflow in middle stage from user mode
    csp = 32'h7fff_fff0;
    set_stage(1, 3'd3, 32'h100, 32'h0);
    push(VEC, 3'b011, 1'b1, 1'b1, 32'h100, 3'd3, "R2 overflow"); step(); settle();
    chk("R4 saved_mode", {31'd0, saved_mode}, 32'd0);
    chk("R4 saved_sp", saved_sp, 32'h7fff_fff0);
    chk("R4 sp_wr", {31'd0, sp_wr}, 32'd1);
    chk("R4 sp_wdata", sp_wdata, 32'h9000_0000);
    chk("R5 exc_en cleared", {31'd0, exc_en}, 32'd0);

    // R5: fault while masked is ignored; R9 interrupt arrives and must wait
    set_stage(2, 3'd6, 32'h180, 32'h4444); irq = 1'b1; step(); settle();
    chk("R5 epc kept", epc, 32'h100);
    chk("R5 cause kept", {29'd0, cause}, 32'd3);
    chk("R5 badvaddr kept", badvaddr, 32'd0);
    chk("R5 no redirect", {31'd0, redirect_vld}, 32'd0);

    // R8: return restores user stack and mode
    eret = 1'b1; push(32'h100, 3'b111, 1'b0, 1'b0, 0, 0, "R8 return"); step(); settle();
    chk("R8 sp_wdata restore", sp_wdata, 32'h7fff_fff0);
    chk("R8 exc_en set", {31'd0, exc_en}, 32'd1);
    // R9: the pending interrupt is taken next, at the oldest stage PC
    spc[2*XL +: XL] = 32'h104;
    push(VEC, 3'b111, 1'b1, 1'b1, 32'h104, 3'd0, "R9 pending irq"); step(); settle();
    eret = 1'b1; push(32'h104, 3'b111, 1'b0, 1'b0, 0, 0, "R8 return2"); step(); settle();

    // R3/R7: three stages fault at once, oldest bad-address wins
    set_stage(0, 3'd2, 32'h10c, 32'h0);
    set_stage(1, 3'd4, 32'h108, 32'h0);
    set_stage(2, 3'd5, 32'h104, 32'hdead_0000);
    push(VEC, 3'b111, 1'b1, 1'b1, 32'h104, 3'd5, "R3 oldest wins"); step(); settle();
    chk("R7 badvaddr loaded", badvaddr, 32'hdead_0000);
    eret = 1'b1; push(32'h104, 3'b111, 1'b0, 1'b0, 0, 0, "R8 return3"); step(); settle();

    // R10: period load from user mode is ignored
    twe = 1'b1; twd = 8'd5; step(); settle();
    chk("R10 user load ignored", {24'd0, tick_period}, 32'd0);
    // R7: syscall in youngest stage leaves badvaddr alone
    set_stage(0, 3'd2, 32'h200, 32'h1234);
    push(VEC, 3'b001, 1'b1, 1'b1, 32'h200, 3'd2, "R7 syscall"); step(); settle();
    chk("R7 badvaddr unchanged", badvaddr, 32'hdead_0000);
    eret = 1'b1; push(32'h200, 3'b111, 1'b0, 1'b0, 0, 0, "R8 return4"); step(); settle();

    // R8: a return from user mode does nothing
    eret = 1'b1; step(); settle();
    chk("R8 user eret ignored", {31'd0, kernel_mode}, 32'd0);

    // R6: privileged op in user mode
    pv[1] = 1'b1; spc[1*XL +: XL] = 32'h300;
    push(VEC, 3'b011, 1'b1, 1'b1, 32'h300, 3'd7, "R6 privilege"); step(); settle();

    // R9: stage fault beats a pending interrupt
    irq = 1'b1; step();
    eret = 1'b1; push(32'h300, 3'b111, 1'b0, 1'b0, 0, 0, "R8 return5"); step();
    set_stage(0, 3'd4, 32'h308, 32'h0);
    push(VEC, 3'b001, 1'b1, 1'b1, 32'h308, 3'd4, "R9 sync first"); step(); settle();
    eret = 1'b1; push(32'h308, 3'b111, 1'b0, 1'b0, 0, 0, "R8 return6"); step();
    spc[2*XL +: XL] = 32'h400;
    push(VEC, 3'b111, 1'b1, 1'b1, 32'h400, 3'd0, "R9 irq after sync"); step(); settle();

    // R9/R10: interrupt beats a pending tick, tick follows
    twe = 1'b1; twd = 8'd2; irq = 1'b1; step();
    repeat (3) step();
    settle();
    chk("R10 kernel load", {24'd0, tick_period}, 32'd2);
    eret = 1'b1; push(32'h400, 3'b111, 1'b0, 1'b0, 0, 0, "R8 return7"); step();
    spc[2*XL +: XL] = 32'h500;
    push(VEC, 3'b111, 1'b1, 1'b1, 32'h500, 3'd0, "R9 irq over tick"); step();
    eret = 1'b1; push(32'h500, 3'b111, 1'b0, 1'b0, 0, 0, "R8 return8"); step();
    spc[2*XL +: XL] = 32'h504;
    push(VEC, 3'b111, 1'b1, 1'b1, 32'h504, 3'd1, "R10 tick cause"); step(); settle();

    // R10: period 4 loaded at cycle c gives a tick trap visible at c+6
    begin
      int c0;
      twe = 1'b1; twd = 8'd4; c0 = cyc; step();
      eret = 1'b1; push(32'h504, 3'b111, 1'b0, 1'b0, 0, 0, "R8 return9"); step();
      spc[2*XL +: XL] = 32'h600;
      push_at(c0 + 6, VEC, 3'b111, 1'b1, 1'b1, 32'h600, 3'd1, "R10 tick timing");
      repeat (4) step();
      settle();
      chk("R10 tick trap mode", {31'd0, kernel_mode}, 32'd1);
    end

    repeat (2) step();
    settle();
    chk("R2 scoreboard drained", q.size(), 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule